// File: doc/BRIEF.md
# PWM Tick Rate Generator

This block produces the count-enable pulses for four pulse-width-modulation channels. A divider turns the core clock into a machine-cycle enable, with a ratio picked by a two-bit divide code and a fast-mode bit. One shared prescaler turns that enable into four rates: the machine-cycle rate itself and that rate divided by 4, 16 and 64. Each channel has its own three-bit select field. It either picks one of these four internal rates or hands the channel over to an external clock pin.

There are two external clock pins. Each passes through a two-stage synchroniser and is then sampled only on machine-cycle enables. A low-to-high change seen between two successive samples produces one tick. Each channel's output is a registered pulse that lasts one core-clock cycle. The counters that act on these pulses, and any register access, belong to neighbouring blocks.

Top module: `pwm_tick_gen`

## Requirements
- R1: The machine-cycle enable fires once every N core cycles, where N depends on `mc_div_i` and `mc_fast_i`. Code 00 gives N=1 with `mc_fast_i`=1 and N=2 with `mc_fast_i`=0. Codes 01 and 10 give N=4. Code 11 gives N=1024.
- R2: When a channel's select field (bits [3c+2:3c] of `ch_sel_i` for channel c) holds 000, that channel ticks once per machine cycle, so once every N core cycles.
- R3: Select 001 gives one tick every 4 machine cycles, 010 every 16 and 011 every 64. All three taps come from one shared six-bit counter, so every /64 tick coincides with a /16 tick, and every /16 tick with a /4 tick.
- R4: A select field with its top bit set (1xx) connects the channel to an external pin. Channels 0 and 1 use `ext_clk_i[0]`, and channels 2 and 3 use `ext_clk_i[1]`. A channel so connected gives no tick while its pin is idle.
- R5: When an external pin holds each high and low level for at least two machine cycles, every rising edge gives exactly one tick. External ticks occur only on machine-cycle enables.
- R6: A new select value is seen on the tick output one core cycle later. Every tick lasts one core cycle, and every tick follows a machine-cycle enable in the previous cycle.
- R7: While `rst` is high, all tick outputs are low. Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_div_i | input | 2 | Machine-cycle divide code |
| mc_fast_i | input | 1 | Selects divide-by-1 rather than divide-by-2 when the code is 00 |
| ch_sel_i | input | 12 | Three-bit rate select per channel, channel 0 in the low bits |
| ext_clk_i | input | 2 | Asynchronous external clock pins |
| tick_o | output | 4 | One-cycle tick enable per channel |

## Verification
The assertions rely on each external pin holding every level for at least two machine cycles. Without that, a short pulse could be lost between samples. They also rely on reset being applied from the first clock edge. The stimulus respects this: external pulses are driven on falling clock edges and held for eight core cycles at a divide ratio of two, which is four machine cycles per level. The select and divide inputs change only between measurements, and each measured interval starts only after two ticks have passed, so the phase offset left by a change does not reach a check.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    localparam int NUM_CH     = 4;
    localparam int NUM_EXT    = 2;
    localparam int SEL_W      = 3;
    localparam int NUM_RATES  = 4;
    localparam int RATE_SHIFT = 2;
    localparam int PRE_W      = (NUM_RATES - 1) * RATE_SHIFT;
    localparam int MC_W       = 10;
    localparam int SYNC_DEPTH = 2;
    localparam int CH_PER_EXT = NUM_CH / NUM_EXT;

    typedef enum logic [1:0] {
        MC_DIV_BASE = 2'b00,
        MC_DIV_QA   = 2'b01,
        MC_DIV_QB   = 2'b10,
        MC_DIV_SLOW = 2'b11
    } mc_div_e;

    typedef struct packed {
        logic       use_ext;
        logic [1:0] rate;
    } tick_sel_t;

    // Terminal count (ratio minus one) of the machine-cycle divider.
    function automatic logic [MC_W-1:0] mc_terminal(input mc_div_e code, input logic fast);
        logic [MC_W-1:0] t;
        case (code)
            MC_DIV_BASE: t = fast ? MC_W'(0) : MC_W'(1);
            MC_DIV_QA,
            MC_DIV_QB:   t = MC_W'(3);
            default:     t = MC_W'(1023);
        endcase
        return t;
    endfunction

    function automatic int ext_of_channel(input int ch);
        return ch / CH_PER_EXT;
    endfunction

endpackage

// File: rtl/pwm_mc_divider.sv
module pwm_mc_divider
    import pwm_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_code,
    input  logic       fast,
    output logic       mc_tick
);
    logic [MC_W-1:0] cnt;
    logic [MC_W-1:0] term;

    always_comb begin
        term    = mc_terminal(mc_div_e'(div_code), fast);
        // >= keeps the divider from running long after a ratio shrinks
        mc_tick = (cnt >= term);
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (mc_tick) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_tick_pkg::*;
#(
    parameter int RATES = NUM_RATES,
    parameter int SHIFT = RATE_SHIFT,
    localparam int CW   = (RATES - 1) * SHIFT
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             mc_tick,
    output logic [RATES-1:0] rate_tick
);
    logic [CW-1:0] pre_cnt;

    always_ff @(posedge clk) begin
        if (rst)          pre_cnt <= '0;
        else if (mc_tick) pre_cnt <= pre_cnt + 1'b1;
    end

    assign rate_tick[0] = mc_tick;

    for (genvar k = 1; k < RATES; k++) begin : g_tap
        assign rate_tick[k] = mc_tick & (&pre_cnt[k*SHIFT-1:0]);
    end
endmodule

// File: rtl/pwm_ext_sampler.sv
module pwm_ext_sampler
    import pwm_tick_pkg::*;
#(
    parameter int PINS  = NUM_EXT,
    parameter int DEPTH = SYNC_DEPTH
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            mc_tick,
    input  logic [PINS-1:0] pin,
    output logic [PINS-1:0] rise
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [DEPTH-1:0] sync_q;
        logic             held;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                held   <= 1'b0;
            end else begin
                sync_q <= {sync_q[DEPTH-2:0], pin[p]};
                if (mc_tick) held <= sync_q[DEPTH-1];
            end
        end

        assign rise[p] = mc_tick & sync_q[DEPTH-1] & ~held;
    end
endmodule

// File: rtl/pwm_tick_mux.sv
module pwm_tick_mux
    import pwm_tick_pkg::*;
#(
    parameter int CH = NUM_CH
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RATES-1:0] rate_tick,
    input  logic [NUM_EXT-1:0]   ext_rise,
    input  logic [CH*SEL_W-1:0]  sel,
    output logic [CH-1:0]        tick
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        tick_sel_t s;
        logic      nxt;

        always_comb begin
            s   = tick_sel_t'(sel[c*SEL_W +: SEL_W]);
            nxt = s.use_ext ? ext_rise[ext_of_channel(c)] : rate_tick[s.rate];
        end

        always_ff @(posedge clk) begin
            if (rst) tick[c] <= 1'b0;
            else     tick[c] <= nxt;
        end
    end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               mc_div_i,
    input  logic                     mc_fast_i,
    input  logic [NUM_CH*SEL_W-1:0]  ch_sel_i,
    input  logic [NUM_EXT-1:0]       ext_clk_i,
    output logic [NUM_CH-1:0]        tick_o
);
    logic                 mc_tick;
    logic [NUM_RATES-1:0] rate_tick;
    logic [NUM_EXT-1:0]   ext_rise;

    pwm_mc_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .div_code (mc_div_i),
        .fast     (mc_fast_i),
        .mc_tick  (mc_tick)
    );

    pwm_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .mc_tick   (mc_tick),
        .rate_tick (rate_tick)
    );

    pwm_ext_sampler u_ext (
        .clk     (clk),
        .rst     (rst),
        .mc_tick (mc_tick),
        .pin     (ext_clk_i),
        .rise    (ext_rise)
    );

    pwm_tick_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .rate_tick (rate_tick),
        .ext_rise  (ext_rise),
        .sel       (ch_sel_i),
        .tick      (tick_o)
    );
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk
    import pwm_tick_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 mc_tick,
    input logic [NUM_RATES-1:0] rate_tick,
    input logic [NUM_EXT-1:0]   ext_rise,
    input logic [NUM_CH-1:0]    tick_o
);
    p_tap4_on_mc_r3: assert property (@(posedge clk) disable iff (rst)
        rate_tick[1] |-> mc_tick);
    p_tap16_in_tap4_r3: assert property (@(posedge clk) disable iff (rst)
        rate_tick[2] |-> rate_tick[1]);
    p_tap64_in_tap16_r3: assert property (@(posedge clk) disable iff (rst)
        rate_tick[3] |-> rate_tick[2]);
    p_ext_on_mc_r5: assert property (@(posedge clk) disable iff (rst)
        (ext_rise != '0) |-> mc_tick);
    p_ext0_single_r5: assert property (@(posedge clk) disable iff (rst)
        ext_rise[0] |=> !ext_rise[0]);
    p_ext1_single_r5: assert property (@(posedge clk) disable iff (rst)
        ext_rise[1] |=> !ext_rise[1]);
    p_tick_after_mc_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_o != '0) |-> $past(mc_tick));
    p_reset_quiet_r7: assert property (@(posedge clk)
        rst |=> (tick_o == '0));
endmodule

bind pwm_tick_gen pwm_tick_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mc_tick   (mc_tick),
    .rate_tick (rate_tick),
    .ext_rise  (ext_rise),
    .tick_o    (tick_o)
);

// File: tb/test_pwm_tick_gen.sv
module test_pwm_tick_gen;
    import pwm_tick_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [1:0]              mc_div_i = 2'b00;
    logic                    mc_fast_i = 1'b1;
    logic [NUM_CH*SEL_W-1:0] ch_sel_i = '0;
    logic [NUM_EXT-1:0]      ext_clk_i = '0;
    logic [NUM_CH-1:0]       tick_o;

    pwm_tick_gen i_pwm_tick_gen (.*);

    always #5 clk = ~clk;

    typedef struct {
        int    ch;
        int    period;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int vectors = 0;
    int miscompares = 0;
    int tick_cnt [NUM_CH];
    int cycles = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            check(1'b0, "watchdog", cycles, 190000);
            finish_run();
        end
    end

    always @(negedge clk)
        for (int c = 0; c < NUM_CH; c++) tick_cnt[c] += int'(tick_o[c]);

    task automatic next_gap(input int ch, output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!tick_o[ch]);
    endtask

    // Monitor: measure the third gap between ticks, compare with expectation.
    initial begin
        forever begin
            sb_item_t it;
            int g;
            wait (sb_q.size() != 0);
            it = sb_q[0];
            next_gap(it.ch, g);
            next_gap(it.ch, g);
            next_gap(it.ch, g);
            check(g == it.period, it.tag, g, it.period);
            void'(sb_q.pop_front());
        end
    end

    function automatic int mc_ratio(input logic [1:0] code, input logic fast);
        if (code == 2'b00) return fast ? 1 : 2;
        if (code == 2'b11) return 1024;
        return 4;
    endfunction

    task automatic set_sel(input int ch, input logic [2:0] v);
        ch_sel_i[ch*SEL_W +: SEL_W] = v;
    endtask

    // Driver: configure, then push one expected period per listed channel.
    task automatic run_rates(input logic [1:0] code, input logic fast,
                             input logic [2:0] s0, input logic [2:0] s1,
                             input logic [2:0] s2, input logic [2:0] s3,
                             input logic [3:0] use_ch, input string tag);
        logic [2:0] s [NUM_CH];
        int n;
        @(negedge clk);
        mc_div_i  = code;
        mc_fast_i = fast;
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        for (int c = 0; c < NUM_CH; c++) set_sel(c, s[c]);
        n = mc_ratio(code, fast);
        repeat (4) @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) begin
            if (use_ch[c]) begin
                sb_item_t it;
                it.ch     = c;
                it.period = n * (1 << (2 * int'(s[c][1:0])));
                it.tag    = $sformatf("%s ch%0d sel%0b", tag, c, s[c]);
                sb_q.push_back(it);
            end
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic pulse_pin(input int p, input int times);
        for (int i = 0; i < times; i++) begin
            @(negedge clk); ext_clk_i[p] = 1'b1;
            repeat (7) @(negedge clk);
            @(negedge clk); ext_clk_i[p] = 1'b0;
            repeat (7) @(negedge clk);
        end
        repeat (12) @(negedge clk);
    endtask

    initial begin
        // R7: outputs quiet in reset even with the fastest rate selected
        repeat (3) @(negedge clk);
        check(tick_o == '0, "R7 reset quiet", int'(tick_o), 0);
        @(negedge clk); rst = 1'b0;

        // R1 R2 R3: period per divide code and tap
        run_rates(2'b00, 1'b1, 3'b000, 3'b001, 3'b010, 3'b011, 4'b1111, "R1 R2 R3 div1");
        run_rates(2'b00, 1'b0, 3'b011, 3'b000, 3'b001, 3'b010, 4'b1111, "R1 R2 R3 div2");
        run_rates(2'b01, 1'b0, 3'b010, 3'b000, 3'b000, 3'b011, 4'b1001, "R1 R3 div4a");
        run_rates(2'b10, 1'b1, 3'b000, 3'b001, 3'b000, 3'b000, 4'b0010, "R1 R3 div4b");
        run_rates(2'b11, 1'b0, 3'b001, 3'b000, 3'b000, 3'b000, 4'b0101, "R1 R2 div1024");

        // R6: select change visible one core cycle later
        @(negedge clk);
        mc_div_i = 2'b00; mc_fast_i = 1'b1;
        for (int c = 0; c < NUM_CH; c++) set_sel(c, 3'b000);
        repeat (3) @(negedge clk);
        check(tick_o[0] == 1'b1, "R6 sel000 ticks every cycle", int'(tick_o[0]), 1);
        set_sel(0, 3'b100);
        @(negedge clk);
        check(tick_o[0] == 1'b0, "R6 switch to idle pin", int'(tick_o[0]), 0);
        set_sel(0, 3'b000);
        @(negedge clk);
        check(tick_o[0] == 1'b1, "R6 switch back", int'(tick_o[0]), 1);

        // R4 R5: external pins, machine cycle = 2 core cycles
        mc_fast_i = 1'b0;
        set_sel(0, 3'b100); set_sel(1, 3'b111);
        set_sel(2, 3'b101); set_sel(3, 3'b110);
        repeat (10) @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) tick_cnt[c] = 0;
        pulse_pin(0, 5);
        check(tick_cnt[0] == 5, "R5 pin0 ch0 edges", tick_cnt[0], 5);
        check(tick_cnt[1] == 5, "R5 pin0 ch1 edges", tick_cnt[1], 5);
        check(tick_cnt[2] == 0, "R4 pin1 idle ch2", tick_cnt[2], 0);
        check(tick_cnt[3] == 0, "R4 pin1 idle ch3", tick_cnt[3], 0);
        for (int c = 0; c < NUM_CH; c++) tick_cnt[c] = 0;
        pulse_pin(1, 3);
        check(tick_cnt[0] == 0, "R4 pin0 idle ch0", tick_cnt[0], 0);
        check(tick_cnt[1] == 0, "R4 pin0 idle ch1", tick_cnt[1], 0);
        check(tick_cnt[2] == 3, "R5 pin1 ch2 edges", tick_cnt[2], 3);
        check(tick_cnt[3] == 3, "R5 pin1 ch3 edges", tick_cnt[3], 3);

        finish_run();
    end
endmodule